// File: doc/BRIEF.md
# Floating-point control and status register

This block is the control and status register of a processor's floating-point unit. Software writes it through a 32-bit register port and reads it back through a read port. The register holds four things: the rounding mode, which goes straight to the arithmetic datapath; an enable bit for floating-point traps; five sticky IEEE exception flags; and four spare storage bits.

The datapath reports the exception conditions of each operation through a strobe that carries five flag bits. The block ORs those flags into the stored copy. When a report carries at least one flag and traps are enabled, the block issues a single-cycle exception request in the following cycle. The trap logic outside the block acts on that request.

Top module: `fpu_csr_reg`

## Requirements
- R1: A write keeps only bits [11:0] of `wr_data`. Bits [31:12] of `rd_data` always read as zero.
- R2: The rounding field sits at register bits [2:1], and `round_mode` always equals it. The encoding is 0 for nearest-even, 1 for toward zero, 2 for toward +infinity and 3 for toward −infinity.
- R3: Each report bit sets one register bit. `flag_bits[0]` (invalid) sets bit 5. `flag_bits[1]` (overflow) sets bit 3. `flag_bits[2]` (underflow) sets bit 4. `flag_bits[3]` (divide-by-zero) sets bit 7. `flag_bits[4]` (inexact) sets bit 6.
- R4: Reported flags are ORed into the stored flags. A stored flag stays set until a software write changes it.
- R5: Bit 0 is the trap enable. A report with at least one flag set while bit 0 is set raises `exc_req` for exactly the next cycle. With bit 0 clear, no request is raised.
- R6: A report with all five flag bits clear changes no register bit and raises no request.
- R7: When a write and a report fall in the same cycle, the write is stored unchanged, the report is discarded and no request follows.
- R8: After reset the register reads zero (nearest-even, traps disabled, no flags) and `exc_req` is low.
- R9: Bits [11:8] are plain storage. They read back as written, and reports never change them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 32 | Software write value |
| rd_data | output | 32 | Current register value, zero-extended |
| flag_vld | input | 1 | Datapath flag report strobe |
| flag_bits | input | 5 | Reported flags: [0] invalid, [1] overflow, [2] underflow, [3] divide-by-zero, [4] inexact |
| round_mode | output | 2 | Rounding mode to the datapath |
| exc_req | output | 1 | One-cycle floating-point exception request |

## Verification
The case that matters most is a software write and a flag report arriving in the same cycle. The bench drives both strobes together in several cases: with the trap enable set before the write, with it set by the write itself, and with flags the write leaves clear. The cycle afterwards must show exactly the written value and no request.

A reference model in the bench checks every step. The bench also checks the opposite ordering: a report in one cycle and a write in the next. There, the request belongs to the report and must still appear.

// File: rtl/fpu_csr_reg.sv
module fpu_csr_reg #(
  parameter int DATA_W = 32,
  parameter int KEEP_W = 12,
  parameter int NFLAG  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              flag_vld,
  input  logic [NFLAG-1:0]  flag_bits,
  output logic [1:0]        round_mode,
  output logic              exc_req
);
  localparam int POS_EN  = 0;
  localparam int POS_RM  = 1;
  localparam int POS_OVF = 3;
  localparam int POS_UNF = 4;
  localparam int POS_INV = 5;
  localparam int POS_INX = 6;
  localparam int POS_DZ  = 7;

  logic [KEEP_W-1:0] csr_q;
  logic [KEEP_W-1:0] flag_set;
  logic              report_hit;

  always_comb begin
    flag_set          = '0;
    flag_set[POS_INV] = flag_bits[0];
    flag_set[POS_OVF] = flag_bits[1];
    flag_set[POS_UNF] = flag_bits[2];
    flag_set[POS_DZ]  = flag_bits[3];
    flag_set[POS_INX] = flag_bits[4];
  end

  assign report_hit = flag_vld && !wr_en && (|flag_bits);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csr_q   <= '0;
      exc_req <= 1'b0;
    end else begin
      if (wr_en)
        csr_q <= wr_data[KEEP_W-1:0];
      else if (report_hit)
        csr_q <= csr_q | flag_set;
      exc_req <= report_hit && csr_q[POS_EN];
    end
  end

  assign rd_data    = {{(DATA_W-KEEP_W){1'b0}}, csr_q};
  assign round_mode = csr_q[POS_RM +: 2];
endmodule

// File: rtl/fpu_csr_reg_chk.sv
module fpu_csr_reg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic [31:0] rd_data,
  input logic        flag_vld,
  input logic [4:0]  flag_bits,
  input logic [1:0]  round_mode,
  input logic        exc_req
);
  assert_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[31:12] == 20'h0);

  assert_write_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data == {20'h0, $past(wr_data[11:0])});

  assert_mode_out_R2: assert property (@(posedge clk) disable iff (!rst_n)
    round_mode == rd_data[2:1]);

  assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (rd_data[7:3] & $past(rd_data[7:3])) == $past(rd_data[7:3]));

  assert_req_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> $past(flag_vld && !wr_en && (|flag_bits) && rd_data[0]));

  assert_req_raise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_vld && !wr_en && (|flag_bits) && rd_data[0]) |=> exc_req);

  assert_empty_report_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_vld && !wr_en && flag_bits == 5'h0) |=> (!exc_req && $stable(rd_data)));

  assert_write_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && flag_vld) |=> !exc_req);

  assert_spare_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_data[11:8]));
endmodule

bind fpu_csr_reg fpu_csr_reg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .flag_vld(flag_vld), .flag_bits(flag_bits),
  .round_mode(round_mode), .exc_req(exc_req)
);

// File: tb/tb_fpu_csr_reg.sv
module tb_fpu_csr_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        flag_vld = 1'b0;
  logic [4:0]  flag_bits = '0;
  logic [1:0]  round_mode;
  logic        exc_req;

  int checks = 0;
  int fails  = 0;
  int mreg   = 0;
  int mreq   = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  fpu_csr_reg dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .flag_vld(flag_vld), .flag_bits(flag_bits),
    .round_mode(round_mode), .exc_req(exc_req)
  );

  function automatic int map_flags(input logic [4:0] f);
    int m = 0;
    if (f[0]) m += 32;
    if (f[1]) m += 8;
    if (f[2]) m += 16;
    if (f[3]) m += 128;
    if (f[4]) m += 64;
    return m;
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    check(tag, "rd_data", int'(rd_data), mreg);
    check(tag, "round_mode", int'(round_mode), (mreg >> 1) & 3);
    check(tag, "exc_req", int'(exc_req), mreq);
  endtask

  task automatic step(input string tag, input bit we, input logic [31:0] wd,
                      input bit fv, input logic [4:0] fb);
    wr_en = we; wr_data = wd; flag_vld = fv; flag_bits = fb;
    @(posedge clk);
    if (we) begin
      mreg = int'(wd & 32'hFFF); mreq = 0;
    end else if (fv && fb != 0) begin
      mreq = mreg & 1; mreg = mreg | map_flags(fb);
    end else mreq = 0;
    @(negedge clk);
    wr_en = 1'b0; flag_vld = 1'b0; flag_bits = '0;
    compare(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    @(negedge clk); @(negedge clk);
    compare("R8");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R8");

    step("R1", 1, 32'hFFFF_F123, 0, 0);
    step("R1", 1, 32'hABCD_E000, 0, 0);
    for (int m = 0; m < 4; m++) step("R2", 1, 32'(m << 1), 0, 0);

    step("R1", 1, 32'h0, 0, 0);
    for (int b = 0; b < 5; b++) begin
      step("R3", 1, 32'h0, 0, 0);
      step("R3", 0, 0, 1, 5'(1 << b));
    end
    step("R4", 1, 32'h0, 0, 0);
    step("R4", 0, 0, 1, 5'b00010);
    step("R4", 0, 0, 1, 5'b10000);
    step("R4", 0, 0, 0, 0);
    step("R4", 0, 0, 1, 5'b00010);

    step("R5", 1, 32'h001, 0, 0);
    step("R5", 0, 0, 1, 5'b00100);
    step("R5", 0, 0, 0, 0);
    step("R5", 0, 0, 1, 5'b01000);
    step("R5", 0, 0, 1, 5'b00001);
    step("R5", 0, 0, 0, 0);
    step("R5", 1, 32'h0, 0, 0);
    step("R5", 0, 0, 1, 5'b11111);

    step("R6", 1, 32'h005, 0, 0);
    step("R6", 0, 0, 1, 5'b00000);
    step("R6", 0, 0, 1, 5'b00000);

    step("R7", 1, 32'h001, 0, 0);
    step("R7", 1, 32'h001, 1, 5'b11111);
    step("R7", 1, 32'h000, 0, 0);
    step("R7", 1, 32'h7F1, 1, 5'b00010);
    step("R7", 0, 0, 1, 5'b00010);
    step("R7", 1, 32'h000, 0, 0);

    step("R9", 1, 32'hA00, 0, 0);
    step("R9", 0, 0, 1, 5'b11111);
    step("R9", 1, 32'h500, 0, 0);
    step("R9", 0, 0, 1, 5'b01010);

    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step("R4", lfsr[3:0] == 4'h0, {lfsr, lfsr}, lfsr[5] | lfsr[6], lfsr[12:8]);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule